// File: doc/BRIEF.md
# PCM Codec Serial Port Master

This block drives the serial link to a voice-band PCM codec that runs as a slave. From the system clock it derives the bit clock sent to the codec and a frame-sync pulse once per sample. In each frame it sends one 16-bit word to the codec's DAC input and takes one 16-bit word from the codec's ADC output. Both words are left-justified and travel MSB first.

The outgoing word comes from one of two places. The host can load a holding register, and that word is sent again in every frame until the host replaces it. In loopback mode the most recently received sample is returned instead. A format input picks the data layout. In 13-bit linear mode the three low bits of the outgoing word carry a receive-volume code. In 8-bit mu-law mode the low byte is sent as zeros.

Each received word is handed to the host over a ready/valid pair. A one-clock event marks the start of every frame, which is the moment the next DAC word is committed.

Top module: `pcm_link_master`

## Requirements
- R1: `sclk` is low after reset. It toggles every `HALF_DIV` system clocks, so its period is 2·`HALF_DIV` clocks at 50 % duty. Its first rising edge comes `HALF_DIV` clocks after reset is released.
- R2: A frame lasts `FRAME_BITS` bit periods. `fsync` is high for exactly one bit period, which is the period just before the outgoing MSB. It changes only together with a rising edge of `sclk`.
- R3: In the 16 bit periods that follow `fsync`, `pcm_dout` presents the outgoing word MSB first (bit 15 first, bit 0 last). It changes together with `sclk` rising and is 0 in every other bit period.
- R4: `pcm_din` is sampled at each falling edge of `sclk` in those 16 bit periods, with bit 15 first. At the falling edge of the last bit, the assembled word appears on `rx_data` and `rx_valid` is set.
- R5: `rx_valid` stays high until a clock edge at which `rx_ready` is high. If a newer word arrives first, `rx_data` takes the newer word and `rx_valid` stays high.
- R6: With `fmt_mulaw` = 0 (linear), the outgoing word is source bits [15:3] followed by `rx_vol` in bits [2:0]. The gain codes are 000 +3 dB, 001 0 dB, 010 −3 dB, 011 −6 dB, 100 −9 dB, 101 −12 dB, 110 −15 dB and 111 −18 dB.
- R7: With `fmt_mulaw` = 1, the outgoing word is source bits [15:8] followed by eight zero bits. `rx_vol` has no effect.
- R8: With `loop_en` = 1, the source is the most recently received word. Otherwise the source is the holding register, which is written by `tx_load` with `tx_word`, clears to 0 on reset, and is repeated in every frame until it is written again.
- R9: `frm_evt` is a single-clock pulse issued with the rising edge of `fsync`. The source, format and volume present at that clock edge decide the word that goes out in that frame.
- R10: While reset is asserted, `sclk`, `fsync`, `pcm_dout`, `frm_evt` and `rx_valid` are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_mulaw | input | 1 | 0 = 13-bit linear, 1 = 8-bit mu-law |
| loop_en | input | 1 | Send the last received word back to the DAC |
| rx_vol | input | 3 | Receive-volume code for linear mode |
| tx_word | input | 16 | Word for the transmit holding register |
| tx_load | input | 1 | Write `tx_word` into the holding register |
| pcm_din | input | 1 | Serial data from the codec ADC |
| rx_ready | input | 1 | Host accepts `rx_data` |
| sclk | output | 1 | Bit clock to the codec |
| fsync | output | 1 | Frame-sync pulse to the codec |
| pcm_dout | output | 1 | Serial data to the codec DAC |
| rx_data | output | 16 | Last received word |
| rx_valid | output | 1 | `rx_data` holds a word not yet accepted |
| frm_evt | output | 1 | Start-of-frame event to the host |

## Verification
The hardest case to reach from the ports is loopback. There, the word sent in one frame depends on the serial input captured during the previous frame, so a loopback error only shows up one frame after its cause. The bench therefore acts as the codec for the whole run, sending a distinct word in every frame. It also drives the inverted bit on every clock edge that is not a sampling edge, so sampling on the wrong edge produces a visible error. The reference model follows the received words and the holding register on its own. Mode and volume changes are applied mid-frame, which checks that only the values present at the frame start count.

// File: rtl/pcm_link_pkg.sv
`timescale 1ns/1ps
package pcm_link_pkg;
    localparam int WORD_W  = 16;
    localparam int VOL_W   = 3;
    localparam int MULAW_W = 8;

    typedef enum logic {FMT_LINEAR = 1'b0, FMT_MULAW = 1'b1} fmt_e;

    typedef struct packed {
        fmt_e             fmt;
        logic             loop;
        logic [VOL_W-1:0] vol;
    } tx_cfg_t;

    // Fit a source sample into the outgoing slot for the selected format.
    function automatic logic [WORD_W-1:0] shape_word(
        input logic [WORD_W-1:0] src,
        input fmt_e              fmt,
        input logic [VOL_W-1:0]  vol
    );
        if (fmt == FMT_MULAW)
            return {src[WORD_W-1 -: MULAW_W], {(WORD_W-MULAW_W){1'b0}}};
        return {src[WORD_W-1:VOL_W], vol};
    endfunction
endpackage

// File: rtl/pcm_bitclk_gen.sv
`timescale 1ns/1ps
module pcm_bitclk_gen #(
    parameter int HALF_DIV   = 2,
    parameter int FRAME_BITS = 256,
    parameter int BIT_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic             sclk_o,
    output logic             fsync_o,
    output logic             rise_o,
    output logic             fall_o,
    output logic [BIT_W-1:0] idx_o,
    output logic [BIT_W-1:0] nxt_o
);
    localparam int HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_BITS-1);

    logic [HC_W-1:0]  hcnt_q;
    logic             sclk_q;
    logic             fsync_q;
    logic [BIT_W-1:0] bcnt_q;
    logic             tick;

    assign tick    = (hcnt_q == HC_W'(HALF_DIV-1));
    assign rise_o  = tick & ~sclk_q;
    assign fall_o  = tick &  sclk_q;
    assign nxt_o   = (bcnt_q == LAST_IDX) ? '0 : bcnt_q + 1'b1;
    assign idx_o   = bcnt_q;
    assign sclk_o  = sclk_q;
    assign fsync_o = fsync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt_q  <= '0;
            sclk_q  <= 1'b0;
            bcnt_q  <= BIT_W'(FRAME_BITS-2);
            fsync_q <= 1'b0;
        end else begin
            hcnt_q <= tick ? '0 : hcnt_q + 1'b1;
            if (tick)
                sclk_q <= ~sclk_q;
            if (rise_o) begin
                bcnt_q  <= nxt_o;
                fsync_q <= (nxt_o == LAST_IDX);
            end
        end
    end

    AST_FSYNC_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        !$stable(fsync_q) |-> $rose(sclk_q)); // R2
endmodule

// File: rtl/pcm_tx_serializer.sv
`timescale 1ns/1ps
module pcm_tx_serializer
    import pcm_link_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int BIT_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              rise_i,
    input  logic [BIT_W-1:0]  nxt_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              dout_o,
    output logic              evt_o
);
    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_BITS-1);

    logic [WORD_W-1:0] sh_q;
    logic              dout_q;
    logic              evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            dout_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            evt_q <= rise_i && (nxt_i == LAST_IDX);
            if (rise_i) begin
                if (nxt_i == LAST_IDX) begin
                    sh_q   <= word_i;
                    dout_q <= 1'b0;
                end else if (nxt_i < BIT_W'(WORD_W)) begin
                    dout_q <= sh_q[WORD_W-1];
                    sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
                end else begin
                    dout_q <= 1'b0;
                end
            end
        end
    end

    assign dout_o = dout_q;
    assign evt_o  = evt_q;

    AST_DOUT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout_q) |-> $rose(sclk_i)); // R3
    AST_EVT_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        evt_q |=> !evt_q); // R9
endmodule

// File: rtl/pcm_rx_deserializer.sv
`timescale 1ns/1ps
module pcm_rx_deserializer
    import pcm_link_pkg::*;
#(
    parameter int BIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              fall_i,
    input  logic [BIT_W-1:0]  idx_i,
    input  logic              din_i,
    input  logic              ready_i,
    output logic [WORD_W-1:0] data_o,
    output logic              valid_o
);
    logic [WORD_W-2:0] sh_q;
    logic [WORD_W-1:0] data_q;
    logic              valid_q;
    logic              in_window;
    logic              done;

    assign in_window = fall_i && (idx_i < BIT_W'(WORD_W));
    assign done      = fall_i && (idx_i == BIT_W'(WORD_W-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (in_window)
                sh_q <= {sh_q[WORD_W-3:0], din_i};
            if (done)
                data_q <= {sh_q, din_i};
            if (done)
                valid_q <= 1'b1;
            else if (ready_i)
                valid_q <= 1'b0;
        end
    end

    assign data_o  = data_q;
    assign valid_o = valid_q;

    AST_VALID_HELD: assert property (@(posedge clk) disable iff (rst)
        valid_q && !ready_i |=> valid_q); // R5
    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_q) |-> $fell(sclk_i)); // R4
endmodule

// File: rtl/pcm_link_master.sv
`timescale 1ns/1ps
module pcm_link_master
    import pcm_link_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int FRAME_BITS = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fmt_mulaw,
    input  logic        loop_en,
    input  logic [2:0]  rx_vol,
    input  logic [15:0] tx_word,
    input  logic        tx_load,
    input  logic        pcm_din,
    input  logic        rx_ready,
    output logic        sclk,
    output logic        fsync,
    output logic        pcm_dout,
    output logic [15:0] rx_data,
    output logic        rx_valid,
    output logic        frm_evt
);
    localparam int BIT_W = $clog2(FRAME_BITS);

    logic              rise, fall;
    logic [BIT_W-1:0]  idx, nxt;
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] next_word;
    tx_cfg_t           cfg;

    assign cfg       = '{fmt: fmt_e'(fmt_mulaw), loop: loop_en, vol: rx_vol};
    assign next_word = shape_word(cfg.loop ? rx_data : hold_q, cfg.fmt, cfg.vol);

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (tx_load)
            hold_q <= tx_word;
    end

    pcm_bitclk_gen #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS), .BIT_W(BIT_W)) u_clk (
        .clk(clk), .rst(rst), .sclk_o(sclk), .fsync_o(fsync),
        .rise_o(rise), .fall_o(fall), .idx_o(idx), .nxt_o(nxt)
    );

    pcm_tx_serializer #(.FRAME_BITS(FRAME_BITS), .BIT_W(BIT_W)) u_tx (
        .clk(clk), .rst(rst), .sclk_i(sclk), .rise_i(rise), .nxt_i(nxt),
        .word_i(next_word), .dout_o(pcm_dout), .evt_o(frm_evt)
    );

    pcm_rx_deserializer #(.BIT_W(BIT_W)) u_rx (
        .clk(clk), .rst(rst), .sclk_i(sclk), .fall_i(fall), .idx_i(idx),
        .din_i(pcm_din), .ready_i(rx_ready), .data_o(rx_data), .valid_o(rx_valid)
    );

    AST_EVT_AT_SYNC: assert property (@(posedge clk) disable iff (rst)
        frm_evt |-> $rose(fsync)); // R9
endmodule

// File: tb/pcm_link_master_tb_top.sv
`timescale 1ns/1ps
module pcm_link_master_tb_top;
    localparam int CLK_T = 10;
    localparam int FR    = 256;
    localparam int HD    = 2;
    localparam int FCYC  = FR * 2 * HD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fmt_mulaw = 1'b0, loop_en = 1'b0, tx_load = 1'b0, rx_ready = 1'b0;
    logic [2:0]  rx_vol = 3'd0;
    logic [15:0] tx_word = 16'h0;
    logic        pcm_din = 1'b0;
    logic        sclk, fsync, pcm_dout, rx_valid, frm_evt;
    logic [15:0] rx_data;

    int tests = 0, fails = 0;
    int e = 0;
    logic [15:0] hold_m = 0, lastrx_m = 0, exp_word = 0, got_word = 0;
    logic        valid_m = 0;
    string       cur_tag = "R8", word_tag = "R8";

    always #(CLK_T/2) clk = ~clk;

    pcm_link_master dut_i (
        .clk(clk), .rst(rst), .fmt_mulaw(fmt_mulaw), .loop_en(loop_en), .rx_vol(rx_vol),
        .tx_word(tx_word), .tx_load(tx_load), .pcm_din(pcm_din), .rx_ready(rx_ready),
        .sclk(sclk), .fsync(fsync), .pcm_dout(pcm_dout), .rx_data(rx_data),
        .rx_valid(rx_valid), .frm_evt(frm_evt)
    );

    function automatic logic [15:0] codec_word(input int f);
        return (16'h9D30 ^ 16'(f * 16'h2468)) & 16'hFFF8;
    endfunction

    function automatic logic [15:0] expect_out(input logic [15:0] src, input logic mu, input logic [2:0] v);
        if (mu) return src & 16'hFF00;
        return (src & 16'hFFF8) | {13'd0, v};
    endfunction

    task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s at edge %0d: got %h expected %h", req, what, e, got, exp);
        end
    endtask

    // Reference model: positions are derived from the edge count since reset.
    always @(posedge clk) begin
        #1;
        if (rst) begin
            e = 0; hold_m = 0; lastrx_m = 0; valid_m = 0; exp_word = 0;
            chk("R10", "sclk",     {15'd0, sclk},     16'd0);
            chk("R10", "fsync",    {15'd0, fsync},    16'd0);
            chk("R10", "dout",     {15'd0, pcm_dout}, 16'd0);
            chk("R10", "evt",      {15'd0, frm_evt},  16'd0);
            chk("R10", "rx_valid", {15'd0, rx_valid}, 16'd0);
            chk("R10", "rx_data",  rx_data,           16'd0);
        end else begin
            int p, s, f, nx;
            bit rise_e, fall_e, done;
            logic bitv, exp_sclk, exp_fs, exp_do, exp_ev;
            e++;
            rise_e = (e >= 2) && ((e - 2) % (2*HD) == 0);
            fall_e = (e >= 4) && (e % (2*HD) == 0);
            p = (e >= 2) ? (e - 2) / (2*HD) : 0;
            s = p % FR;
            f = p / FR;
            if (rise_e && s == 0) begin
                exp_word = expect_out(loop_en ? lastrx_m : hold_m, fmt_mulaw, rx_vol);
                word_tag = cur_tag;
                got_word = 0;
            end
            done = fall_e && (s == 16);
            if (done) lastrx_m = codec_word(f);
            valid_m = done ? 1'b1 : (valid_m && !rx_ready);
            if (tx_load) hold_m = tx_word;

            exp_sclk = (e >= 2) ? 1'((e / HD) % 2) : 1'b0;
            exp_fs   = (e >= 2) && (s == 0);
            exp_do   = (e >= 2 && s >= 1 && s <= 16) ? exp_word[16 - s] : 1'b0;
            exp_ev   = (e >= 2) && ((e - 2) % FCYC == 0);
            chk("R1", "sclk",     {15'd0, sclk},     {15'd0, exp_sclk});
            chk("R2", "fsync",    {15'd0, fsync},    {15'd0, exp_fs});
            chk("R3", "dout",     {15'd0, pcm_dout}, {15'd0, exp_do});
            chk("R9", "evt",      {15'd0, frm_evt},  {15'd0, exp_ev});
            chk("R5", "rx_valid", {15'd0, rx_valid}, {15'd0, valid_m});
            chk("R4", "rx_data",  rx_data,           lastrx_m);

            if (rise_e && s >= 1 && s <= 16) begin
                got_word[16 - s] = pcm_dout;
                if (s == 16) chk(word_tag, "frame word", got_word, exp_word);
            end

            // Codec model: correct bit on sampling edges, inverted elsewhere.
            nx = e + 1;
            bitv = 1'b0;
            if (nx >= 2) begin
                p = (nx - 2) / (2*HD);
                s = p % FR;
                if (s >= 1 && s <= 16) bitv = codec_word(p / FR)[16 - s];
            end
            pcm_din = (nx % (2*HD) == 0) ? bitv : ~bitv;
        end
    end

    task automatic setup_frame(input string tag, input logic mu, input logic lp, input logic [2:0] v,
                               input logic ld, input logic [15:0] w, input logic rdy);
        @(negedge clk);
        while (!(e >= 2 && ((e - 2) % FCYC) == FCYC / 2)) @(negedge clk);
        cur_tag = tag; fmt_mulaw = mu; loop_en = lp; rx_vol = v; rx_ready = rdy;
        if (ld) begin
            tx_word = w; tx_load = 1'b1;
            @(negedge clk);
            tx_load = 1'b0;
        end
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(CLK_T * 200000);
        fails++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        setup_frame("R6", 1'b0, 1'b0, 3'd5, 1'b1, 16'hA5C3, 1'b0);
        setup_frame("R8", 1'b0, 1'b0, 3'd0, 1'b0, 16'h0000, 1'b0); // repeat held word
        setup_frame("R6", 1'b0, 1'b0, 3'd7, 1'b1, 16'h1234, 1'b0);
        setup_frame("R6", 1'b0, 1'b0, 3'd1, 1'b1, 16'hFFFF, 1'b1);
        setup_frame("R7", 1'b1, 1'b0, 3'd6, 1'b1, 16'h8E71, 1'b1);
        setup_frame("R7", 1'b1, 1'b0, 3'd2, 1'b0, 16'h0000, 1'b0);
        setup_frame("R8", 1'b0, 1'b1, 3'd3, 1'b0, 16'h0000, 1'b0);
        setup_frame("R8", 1'b0, 1'b1, 3'd4, 1'b1, 16'h5A5A, 1'b1);
        setup_frame("R8", 1'b1, 1'b1, 3'd5, 1'b0, 16'h0000, 1'b0);
        setup_frame("R6", 1'b0, 1'b0, 3'd6, 1'b1, 16'h0000, 1'b1);
        repeat (FCYC + 100) @(negedge clk);
        summary();
    end
endmodule